// File: doc/BRIEF.md
# Serial Configuration Stream Structure Checker

This block watches a serial FPGA configuration stream, one bit per clock whenever a valid strobe is high, and checks its framing as the bits arrive. It walks the stream as a fixed sequence of fields. A header comes first: an all-ones lead byte, a 4-bit sync code, a 24-bit length value sent most significant bit first, and a pad nibble of ones. After the header come the configuration frames, each of fixed size. Each frame holds one start bit, a run of payload bits that are not checked, and a 4-bit check nibble that is compared with a constant. A per-device closing byte follows the last frame. Bits that arrive after the closing byte are counted and not inspected.

Frame size and frame count are derived from the `ROWS` and `COLS` parameters. Each adds a fixed edge overhead: a frame is `10*ROWS + 26` bits long and a stream has `36*COLS + 68` frames. A fault in any fixed field sets its own sticky flag and halts the parser until reset. A clean closing byte raises a one-cycle completion pulse. At that point the number of bits received since the header is also compared with the captured length value.

Top module: `bsc_checker`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, `err_flags`, `frame_count`, `length_count`, `tail_count` and `done` are all zero.
- R2: The first eight accepted bits must all be 1, and a wrong bit sets `err_flags[0]`. The next four bits, in arrival order, must be 0,0,1,0, and a wrong bit sets `err_flags[1]`.
- R3: The next 24 accepted bits are shifted into `length_count`, with the first bit ending up as bit 23. They are followed by four bits that must all be 1, and a wrong bit there sets `err_flags[0]`.
- R4: A frame is `10*ROWS+26` bits long. Its first bit must be 0, and a wrong bit sets `err_flags[2]`. It is followed by `10*ROWS+21` payload bits whose values are not checked. The frame ends with four bits that must be 0,1,1,0 in arrival order, and a wrong bit sets `err_flags[3]`.
- R5: `frame_count` goes up by one for each frame whose check nibble passes. After `36*COLS+68` frames the parser moves to the closing byte.
- R6: The closing byte must be 0,1,1,1,1,1,1,1 in arrival order, and a wrong bit sets `err_flags[4]`. When it passes, `done` is high for exactly one cycle.
- R7: The count of accepted bits from the first frame's start bit through the last closing bit is compared with `length_count`. If they differ, `err_flags[5]` is set in the same cycle that `done` rises.
- R8: A fault in any fixed field stops the parse until reset. After it, no further flag is set and `frame_count`, `length_count` and `tail_count` stay unchanged, whatever bits follow.
- R9: A cycle with `bit_valid` low consumes no bit. No counter, flag or captured value changes, whatever `bit_in` holds.
- R10: After `done`, each accepted bit adds one to `tail_count` (saturating), with its value ignored and no flag set.
- R11: A synchronous reset in the middle of a stream restarts the parse at the lead byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | `bit_in` holds a stream bit this cycle |
| bit_in | input | 1 | Serial stream bit |
| length_count | output | LEN_W (24) | Length value captured from the header |
| frame_count | output | clog2(36*COLS+69) | Frames whose check nibble passed |
| tail_count | output | TAIL_W (16) | Bits accepted after the closing byte |
| done | output | 1 | One-cycle pulse when the closing byte passes |
| err_flags | output | 6 | Sticky faults: 0 fill, 1 sync, 2 start, 3 check, 4 closing, 5 length |

## Verification
The bench first sends a clean stream with random payload bits, and then the same stream with an idle cycle after every bit and junk on `bit_in` during the idle cycles. These two runs separate real consumption from strobe-gated consumption. It then corrupts one fixed field per run: the lead byte, the sync code, the pad nibble, a start bit in the first or a middle frame, the check nibble in a middle or the last frame, and the closing byte. Each run must raise exactly its own flag with the right frame count, which shows both which field was blamed and where the parse halted. A stream carrying a length value off by one, a run with trailing bits, a reset in mid-stream and garbage sent after a fault cover the length comparison, the tail counter, the restart and the halt.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic [3:0] {
    ST_LEAD, ST_SYNC, ST_LEN, ST_PAD, ST_SB, ST_BODY, ST_CHK, ST_POST, ST_TAIL, ST_HALT
  } bsc_state_e;

  localparam int ERR_W  = 6;
  localparam int E_FILL = 0;
  localparam int E_SYNC = 1;
  localparam int E_SB   = 2;
  localparam int E_CHK  = 3;
  localparam int E_POST = 4;
  localparam int E_LEN  = 5;

  // codes are compared first-arriving bit = MSB
  localparam logic [3:0] SYNC_CODE  = 4'b0010;
  localparam logic [3:0] CHECK_CODE = 4'b0110;
  localparam logic [7:0] POST_CODE  = 8'b0111_1111;

  // row bits plus top/bottom edges, two spare bits (one is the start bit) and check nibble
  function automatic int frame_bits(input int rows);
    return 10 * rows + 7 + 13 + 1 + 1 + 4;
  endfunction

  // column frames plus left/right edge frames and one extra
  function automatic int frame_total(input int cols);
    return 36 * cols + 26 + 41 + 1;
  endfunction

endpackage

// File: rtl/bsc_field_pos.sv
module bsc_field_pos #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          last,
  output logic [PW-1:0] pos
);
  always_ff @(posedge clk) begin
    if (rst)               pos <= '0;
    else if (step && last) pos <= '0;
    else if (step)         pos <= pos + 1'b1;
  end
endmodule

// File: rtl/bsc_len_track.sv
module bsc_len_track #(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_en,
  input  logic             count_en,
  input  logic             bit_in,
  output logic [LEN_W-1:0] len_q,
  output logic [LEN_W-1:0] rx_cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      len_q  <= '0;
      rx_cnt <= '0;
    end else begin
      if (shift_en) len_q  <= {len_q[LEN_W-2:0], bit_in};
      if (count_en) rx_cnt <= rx_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bsc_err_flags.sv
module bsc_err_flags import bsc_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  logic [ERR_W-1:0] set_v,
  output logic [ERR_W-1:0] flags
);
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= flags | set_v;
  end

  // R8: flags never drop until reset
  a_r8_flags_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/bsc_checker.sv
module bsc_checker import bsc_pkg::*; #(
  parameter int ROWS   = 20,
  parameter int COLS   = 20,
  parameter int LEN_W  = 24,
  parameter int TAIL_W = 16,
  localparam int NFR   = frame_total(COLS),
  localparam int FCW   = $clog2(NFR + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_valid,
  input  logic             bit_in,
  output logic [LEN_W-1:0] length_count,
  output logic [FCW-1:0]   frame_count,
  output logic [TAIL_W-1:0] tail_count,
  output logic             done,
  output logic [ERR_W-1:0] err_flags
);
  localparam int BPF   = frame_bits(ROWS);
  localparam int DBITS = BPF - 5;
  localparam int MAXF  = (DBITS > LEN_W) ? DBITS : LEN_W;
  localparam int PW    = $clog2(MAXF);

  bsc_state_e st_q, st_d;
  logic [PW-1:0]    pos, lastpos;
  logic             step, pos_last, fixed, exp_b, bad, len_mis, post_ok;
  logic [ERR_W-1:0] set_v;
  logic [LEN_W-1:0] rx_cnt;

  assign step     = bit_valid && (st_q != ST_TAIL) && (st_q != ST_HALT);
  assign pos_last = (pos == lastpos);

  always_comb begin
    lastpos = '0;
    fixed   = 1'b1;
    exp_b   = 1'b1;
    case (st_q)
      ST_LEAD: begin lastpos = PW'(7); exp_b = 1'b1; end
      ST_SYNC: begin lastpos = PW'(3); exp_b = SYNC_CODE[~pos[1:0]]; end
      ST_LEN:  begin lastpos = PW'(LEN_W - 1); fixed = 1'b0; end
      ST_PAD:  begin lastpos = PW'(3); exp_b = 1'b1; end
      ST_SB:   begin lastpos = '0; exp_b = 1'b0; end
      ST_BODY: begin lastpos = PW'(DBITS - 1); fixed = 1'b0; end
      ST_CHK:  begin lastpos = PW'(3); exp_b = CHECK_CODE[~pos[1:0]]; end
      ST_POST: begin lastpos = PW'(7); exp_b = POST_CODE[~pos[2:0]]; end
      default: fixed = 1'b0;
    endcase
  end

  assign bad     = step && fixed && (bit_in != exp_b);
  assign post_ok = step && (st_q == ST_POST) && pos_last && !bad;
  assign len_mis = post_ok && ((rx_cnt + 1'b1) != length_count);

  always_comb begin
    set_v = '0;
    if (bad) begin
      case (st_q)
        ST_LEAD, ST_PAD: set_v[E_FILL] = 1'b1;
        ST_SYNC:         set_v[E_SYNC] = 1'b1;
        ST_SB:           set_v[E_SB]   = 1'b1;
        ST_CHK:          set_v[E_CHK]  = 1'b1;
        default:         set_v[E_POST] = 1'b1;
      endcase
    end
    set_v[E_LEN] = len_mis;
  end

  always_comb begin
    st_d = st_q;
    if (step) begin
      if (bad) st_d = ST_HALT;
      else if (pos_last) begin
        case (st_q)
          ST_LEAD: st_d = ST_SYNC;
          ST_SYNC: st_d = ST_LEN;
          ST_LEN:  st_d = ST_PAD;
          ST_PAD:  st_d = ST_SB;
          ST_SB:   st_d = ST_BODY;
          ST_BODY: st_d = ST_CHK;
          ST_CHK:  st_d = (frame_count == FCW'(NFR - 1)) ? ST_POST : ST_SB;
          ST_POST: st_d = ST_TAIL;
          default: st_d = st_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_LEAD;
      frame_count <= '0;
      tail_count  <= '0;
      done        <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= post_ok;
      if (step && (st_q == ST_CHK) && pos_last && !bad) frame_count <= frame_count + 1'b1;
      if (bit_valid && (st_q == ST_TAIL) && (tail_count != '1)) tail_count <= tail_count + 1'b1;
    end
  end

  bsc_field_pos #(.PW(PW)) u_pos (
    .clk(clk), .rst(rst), .step(step), .last(pos_last), .pos(pos)
  );

  bsc_len_track #(.LEN_W(LEN_W)) u_len (
    .clk(clk), .rst(rst),
    .shift_en(step && (st_q == ST_LEN)),
    .count_en(step && (st_q inside {ST_SB, ST_BODY, ST_CHK, ST_POST})),
    .bit_in(bit_in), .len_q(length_count), .rx_cnt(rx_cnt)
  );

  bsc_err_flags u_err (
    .clk(clk), .rst(rst), .set_v(set_v), .flags(err_flags)
  );

  // R9: idle cycles leave every counter alone
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (rst)
    !bit_valid |=> ($stable(frame_count) && $stable(length_count) && $stable(tail_count)));
  // R6: completion is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R6: completion never accompanies a fixed-field fault
  a_r6_done_clean: assert property (@(posedge clk) disable iff (rst)
    done |-> (err_flags[E_POST:E_FILL] == '0));
  // R5: frame counter stays within the stream's frame total
  a_r5_frames_bounded: assert property (@(posedge clk) disable iff (rst)
    frame_count <= FCW'(NFR));
  // R8: after a field fault nothing advances
  a_r8_halt_freezes: assert property (@(posedge clk) disable iff (rst)
    (err_flags[E_POST:E_FILL] != '0) |=> ($stable(frame_count) && $stable(length_count) && $stable(tail_count)));
endmodule

// File: tb/bsc_checker_bench.sv
module bsc_checker_bench;
  localparam int ROWS  = 1;
  localparam int COLS  = 1;
  localparam int BPF   = 10 * ROWS + 26;
  localparam int DBITS = BPF - 5;
  localparam int NFR   = 36 * COLS + 68;
  localparam int FCW   = $clog2(NFR + 1);
  localparam int BODY  = NFR * BPF + 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic [23:0]    length_count;
  logic [FCW-1:0] frame_count;
  logic [15:0]    tail_count;
  logic           done;
  logic [5:0]     err_flags;

  int n_chk = 0;
  int n_bad = 0;
  int done_pulses = 0;

  always #10ns clk = ~clk;

  bsc_checker #(.ROWS(ROWS), .COLS(COLS)) u_bsc_checker (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in),
    .length_count(length_count), .frame_count(frame_count), .tail_count(tail_count),
    .done(done), .err_flags(err_flags)
  );

  always @(negedge clk) if (!rst && done) done_pulses++;

  // {kind[27:24], frame[23:16], flags[15:10], frames[9:2], done[1], stall[0]}
  // kind: 0 clean, 1 lead, 2 sync, 3 pad, 4 start bit, 5 check, 6 closing, 7 length off by one
  localparam logic [27:0] TBL [11] = '{
    {4'd0, 8'd0,   6'b000000, 8'd104, 1'b1, 1'b0},
    {4'd1, 8'd0,   6'b000001, 8'd0,   1'b0, 1'b0},
    {4'd2, 8'd0,   6'b000010, 8'd0,   1'b0, 1'b0},
    {4'd3, 8'd0,   6'b000001, 8'd0,   1'b0, 1'b0},
    {4'd4, 8'd5,   6'b000100, 8'd5,   1'b0, 1'b0},
    {4'd5, 8'd7,   6'b001000, 8'd7,   1'b0, 1'b0},
    {4'd6, 8'd0,   6'b010000, 8'd104, 1'b0, 1'b0},
    {4'd7, 8'd0,   6'b100000, 8'd104, 1'b1, 1'b0},
    {4'd0, 8'd0,   6'b000000, 8'd104, 1'b1, 1'b1},
    {4'd4, 8'd0,   6'b000100, 8'd0,   1'b0, 1'b0},
    {4'd5, 8'd103, 6'b001000, 8'd103, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; bit_valid = 1'b0;
    @(negedge clk);
    @(negedge clk); rst = 1'b0; done_pulses = 0;
  endtask

  task automatic put_bit(input logic b, input logic stall);
    @(negedge clk); bit_valid = 1'b1; bit_in = b;
    if (stall) begin
      @(negedge clk); bit_valid = 1'b0; bit_in = ~b;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_valid = 1'b0; bit_in = i[0];
    end
  endtask

  task automatic send_stream(input int kind, input int fidx, input logic stall);
    logic [23:0] lenval;
    logic b;
    lenval = (kind == 7) ? 24'(BODY - 1) : 24'(BODY);
    for (int i = 0; i < 8; i++) put_bit((kind == 1 && i == 3) ? 1'b0 : 1'b1, stall);
    for (int i = 0; i < 4; i++) begin
      b = 4'b0010 >> (3 - i);
      put_bit((kind == 2 && i == 2) ? ~b : b, stall);
    end
    for (int i = 23; i >= 0; i--) put_bit(lenval[i], stall);
    for (int i = 0; i < 4; i++) put_bit((kind == 3 && i == 1) ? 1'b0 : 1'b1, stall);
    for (int f = 0; f < NFR; f++) begin
      put_bit((kind == 4 && f == fidx) ? 1'b1 : 1'b0, stall);
      for (int d = 0; d < DBITS; d++) put_bit(1'($urandom), stall);
      for (int i = 0; i < 4; i++) begin
        b = 4'b0110 >> (3 - i);
        put_bit((kind == 5 && f == fidx && i == 0) ? ~b : b, stall);
      end
    end
    for (int i = 0; i < 8; i++) begin
      b = 8'b0111_1111 >> (7 - i);
      put_bit((kind == 6 && i == 7) ? ~b : b, stall);
    end
    idle(2);
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [27:0] v;
    int kind;
    logic [23:0] exp_len;

    // R1: reset state
    do_reset();
    check("R1 flags", 32'(err_flags), 0);
    check("R1 frames", 32'(frame_count), 0);
    check("R1 length", 32'(length_count), 0);
    check("R1 tail", 32'(tail_count), 0);
    check("R1 done", 32'(done), 0);

    // table: R2 R3 R4 R5 R6 R7 R8 R9
    for (int t = 0; t < 11; t++) begin
      v = TBL[t];
      kind = int'(v[27:24]);
      do_reset();
      send_stream(kind, int'(v[23:16]), v[0]);
      exp_len = (kind == 1 || kind == 2) ? 24'd0 : ((kind == 7) ? 24'(BODY - 1) : 24'(BODY));
      check("R2/R4/R6 flags", 32'(err_flags), 32'(v[15:10]));
      check("R5 frames", 32'(frame_count), 32'(v[9:2]));
      check("R6 done pulses", 32'(done_pulses), 32'(v[1]));
      check("R3 length", 32'(length_count), 32'(exp_len));
      check("R8 tail", 32'(tail_count), 0);
    end

    // R8: garbage after a start-bit fault changes nothing
    do_reset();
    send_stream(4, 5, 1'b0);
    for (int i = 0; i < 60; i++) put_bit(i[1], 1'b0);
    idle(2);
    check("R8 flags frozen", 32'(err_flags), 32'(6'b000100));
    check("R8 frames frozen", 32'(frame_count), 5);
    check("R8 tail frozen", 32'(tail_count), 0);

    // R9: idle cycles with toggling data during the length field
    do_reset();
    for (int i = 0; i < 8; i++) put_bit(1'b1, 1'b0);
    for (int i = 0; i < 4; i++) put_bit(1'(4'b0010 >> (3 - i)), 1'b0);
    for (int i = 23; i >= 12; i--) put_bit(1'(BODY >> i), 1'b0);
    idle(10);
    check("R9 length held", 32'(length_count), 32'(BODY >> 12));
    check("R9 flags", 32'(err_flags), 0);

    // R11: reset mid-stream, then a clean stream
    do_reset();
    check("R11 length cleared", 32'(length_count), 0);
    send_stream(0, 0, 1'b0);
    check("R11 flags", 32'(err_flags), 0);
    check("R11 frames", 32'(frame_count), NFR);

    // R10: trailing bits are counted, not checked
    for (int i = 0; i < 20; i++) put_bit(1'($urandom), 1'b0);
    idle(2);
    check("R10 tail count", 32'(tail_count), 20);
    check("R10 flags", 32'(err_flags), 0);
    check("R10 done once", 32'(done_pulses), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule